// File: doc/BRIEF.md
# Seven-to-one serial pixel lane receiver

This block turns a group of serial lanes back into a parallel pixel bus. It runs on a bit clock at seven times the pixel rate. Each data lane carries one 7-bit slot group per pixel period. A companion clock lane repeats a fixed high/low shape once per period. The receiver looks for that shape in the sampled clock lane to find the word boundary. It then collects the seven slots of every data lane into one word and places all lane words side by side on the output bus.

The wide build has four lanes and a 28-bit bus. That bus carries 24 colour bits plus horizontal sync, vertical sync, data enable and one control bit. The narrow build has three lanes and a 21-bit bus, carrying 18 colour bits plus the two syncs and data enable. Which bus bit plays which role is set by board wiring; the block only fixes how lane slots map to bus bits.

A recovered pixel clock comes out next to the bus, and a downstream register captures the bus on that clock's falling edge. After framing is found, the receiver waits for a lock interval before any data is shown. Losing the frame shape, or pulling the active-low power-down input low, forces every output low.

Top module: `serial_pixel_rx`

## Requirements
- R1: While reset is held and on the first edges after it, `pix_data` and `pix_clk` are 0.
- R2: With `WIDE`=1 there are 4 lanes and a 28-bit bus. With `WIDE`=0 there are 3 lanes and a 21-bit bus. The narrow bus equals the low 21 bits the wide build produces from the same first three lanes.
- R3: Within a pixel period, the first slot of lane l becomes bus bit 7*l+6 and the last slot becomes bus bit 7*l. Slot k therefore lands on bit 7*l+6-k.
- R4: A frame is good when the seven clock-lane slots of a period read 1,1,1,1,0,0,0 from first to last. The first good frame sets the boundary. Framing is declared when three consecutive good frames line up with that boundary.
- R5: After framing, `LOCK_PIX` further good frames must pass before data is shown, and `pix_data` stays 0 until then. With `LOCK_PIX`=4, the word of the 8th good frame is the first one shown.
- R6: `pix_clk` is high for 4 bit-clock cycles and low for 3 in each period. It rises on the edge that loads a new word. `pix_data` changes only on that edge, or when it is forced to 0.
- R7: A single frame with a wrong clock-lane shape keeps lock. The next good frame's word appears normally.
- R8: Two consecutive bad frames drop lock. `pix_data` goes 0, and the full R4/R5 acquisition is needed again.
- R9: While `pdn_n` is low, `pix_data` and `pix_clk` are 0 from the next bit-clock edge onward. After release, the R4/R5 acquisition starts over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_n | input | 1 | Active-low power-down |
| lane_clk | input | 1 | Sampled framing clock lane |
| lane_dat | input | LANES | Sampled serial data lanes |
| pix_clk | output | 1 | Recovered pixel clock, falling edge is the strobe |
| pix_data | output | 7*LANES | Parallel pixel bus |

## Verification
Random words check the mapping from lane slots to bus bits in general. All-ones, alternating and walking-one words show whether a slot is dropped, swapped or taken from the wrong lane. Clock-lane shapes that break the 1111000 pattern for one frame and for two frames separate tolerance from loss of lock. Power-down applied mid-stream and then released checks that the outputs are forced low and that the whole acquisition runs again.

// File: rtl/serial_pixel_rx.sv
module serial_pixel_rx #(
  parameter int WIDE = 1,
  parameter int LOCK_PIX = 650000,
  localparam int LANES = (WIDE != 0) ? 4 : 3,
  localparam int OUT_W = 7 * LANES
) (
  input  logic             clk_bit,
  input  logic             rst_n,
  input  logic             pdn_n,
  input  logic             lane_clk,
  input  logic [LANES-1:0] lane_dat,
  output logic             pix_clk,
  output logic [OUT_W-1:0] pix_data
);
  localparam int CW = $clog2(LOCK_PIX + 1);

  logic [5:0]    ck_sh;
  logic [2:0]    phase;
  logic [1:0]    good;
  logic          framed, miss;
  logic [CW-1:0] lock_cnt;
  logic [OUT_W-1:0] word_now;

  wire [6:0] ck_win    = {ck_sh, lane_clk};
  wire       match     = (ck_win == 7'b1111000);
  wire       lock_done = (lock_cnt == CW'(LOCK_PIX));
  wire       aligned   = framed || (good != 2'd0);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [5:0] dsh;
    always_ff @(posedge clk_bit or negedge rst_n)
      if (!rst_n) dsh <= '0;
      else        dsh <= {dsh[4:0], lane_dat[l]};
    assign word_now[7*l +: 7] = {dsh, lane_dat[l]};
  end

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n || !pdn_n) begin
      ck_sh <= '0; phase <= '0; good <= '0; framed <= 1'b0; miss <= 1'b0;
      lock_cnt <= '0; pix_data <= '0; pix_clk <= 1'b0;
    end else begin
      ck_sh <= ck_win[5:0];
      if (!aligned) begin
        pix_data <= '0;
        pix_clk  <= match;
        if (match) begin
          phase <= 3'd0;
          good  <= 2'd1;
        end
      end else begin
        phase   <= (phase == 3'd6) ? 3'd0 : phase + 3'd1;
        pix_clk <= (phase == 3'd6) || (phase < 3'd3);
        if (phase == 3'd6) begin
          if (match) begin
            miss <= 1'b0;
            if (!framed) begin
              good <= good + 2'd1;
              if (good == 2'd2) framed <= 1'b1;
            end else if (!lock_done) begin
              lock_cnt <= lock_cnt + 1'b1;
            end
            pix_data <= (framed && lock_done) ? word_now : '0;
          end else if (framed && !miss) begin
            miss     <= 1'b1;
            pix_data <= lock_done ? word_now : '0;
          end else begin
            good <= '0; framed <= 1'b0; miss <= 1'b0; lock_cnt <= '0;
            pix_data <= '0; pix_clk <= 1'b0;
          end
        end
      end
    end
  end
endmodule

module serial_pixel_rx_chk #(parameter int OW = 28) (
  input logic          clk_bit,
  input logic          rst_n,
  input logic          pdn_n,
  input logic          pix_clk,
  input logic [OW-1:0] pix_data
);
  p_pdn_quiet_r9: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !pdn_n |=> (pix_data == '0 && !pix_clk));

  p_data_at_rise_r6: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (!$stable(pix_data) && $past(pdn_n)) |-> ($rose(pix_clk) || pix_data == '0));

  p_clk_high4_r6: assert property (@(posedge clk_bit) disable iff (!rst_n || !pdn_n)
    $rose(pix_clk) |=> pix_clk ##1 pix_clk ##1 pix_clk ##1 !pix_clk);

  p_clk_low3_r6: assert property (@(posedge clk_bit) disable iff (!rst_n || !pdn_n)
    $fell(pix_clk) |=> !pix_clk ##1 !pix_clk);

  always @(posedge clk_bit)
    if (!rst_n) p_reset_low_r1: assert (pix_data == '0 && !pix_clk);
endmodule

bind serial_pixel_rx serial_pixel_rx_chk #(.OW(OUT_W)) u_chk (
  .clk_bit(clk_bit), .rst_n(rst_n), .pdn_n(pdn_n),
  .pix_clk(pix_clk), .pix_data(pix_data)
);

// File: tb/test_serial_pixel_rx.sv
module test_serial_pixel_rx;
  logic clk = 1'b0, rst_n = 1'b0, pdn_n = 1'b1, lane_clk = 1'b0;
  logic [3:0] lane_dat = '0;
  wire pix_clk, pix_clk_n;
  wire [27:0] pix_data;
  wire [20:0] pix_data_n;
  int vecs = 0, errs = 0;
  logic [6:0] clk_seen;
  bit data_steady;

  always #5 clk = ~clk;

  serial_pixel_rx #(.WIDE(1), .LOCK_PIX(4)) i_serial_pixel_rx (
    .clk_bit(clk), .rst_n(rst_n), .pdn_n(pdn_n), .lane_clk(lane_clk),
    .lane_dat(lane_dat), .pix_clk(pix_clk), .pix_data(pix_data));

  serial_pixel_rx #(.WIDE(0), .LOCK_PIX(4)) i_serial_pixel_rx_n (
    .clk_bit(clk), .rst_n(rst_n), .pdn_n(pdn_n), .lane_clk(lane_clk),
    .lane_dat(lane_dat[2:0]), .pix_clk(pix_clk_n), .pix_data(pix_data_n));

  task automatic chk(input string req, input logic [27:0] act, input logic [27:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [27:0] w, input bit good_clk);
    logic [27:0] d0;
    data_steady = 1'b1;
    d0 = pix_data;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      clk_seen[6-k] = pix_clk;
      if (pix_data !== d0) data_steady = 1'b0;
      lane_clk = good_clk ? (k < 4) : 1'b1;
      for (int l = 0; l < 4; l++) lane_dat[l] = w[7*l + 6 - k];
    end
    @(posedge clk); #1;
  endtask

  task automatic acquire(input string req);
    logic [27:0] w;
    for (int i = 1; i <= 7; i++) begin
      frame($urandom, 1'b1);
      chk({req, " R5 held low"}, pix_data, 28'h0);
    end
    w = $urandom;
    frame(w, 1'b1);
    chk({req, " R5 first word"}, pix_data, w);
    chk({req, " R2 narrow"}, {7'h0, pix_data_n}, {7'h0, w[20:0]});
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 data", pix_data, 28'h0);
    chk("R1 clk", {27'h0, pix_clk}, 28'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 data after release", pix_data, 28'h0);
  endtask

  task automatic t_acquire;
    frame(28'h1234567, 1'b1);
    chk("R4 boundary found, clk rises", {27'h0, pix_clk}, 28'h1);
    chk("R4 no data yet", pix_data, 28'h0);
    for (int i = 2; i <= 7; i++) begin
      frame($urandom, 1'b1);
      chk("R4/R5 held low during acquisition", pix_data, 28'h0);
    end
    begin
      logic [27:0] w = 28'hABCDEF1;
      frame(w, 1'b1);
      chk("R5 first shown word", pix_data, w);
    end
  endtask

  task automatic t_patterns;
    logic [27:0] pats [4];
    pats[0] = 28'hFFFFFFF; pats[1] = 28'h5555555; pats[2] = 28'hAAAAAAA; pats[3] = 28'h0000001;
    for (int i = 0; i < 4; i++) begin
      frame(pats[i], 1'b1);
      chk("R3 fixed pattern", pix_data, pats[i]);
    end
    for (int b = 0; b < 28; b += 5) begin
      frame(28'h1 << b, 1'b1);
      chk("R3 walking one", pix_data, 28'h1 << b);
    end
    for (int i = 0; i < 10; i++) begin
      logic [27:0] w = $urandom;
      frame(w, 1'b1);
      chk("R3 random word", pix_data, w);
      chk("R2 narrow bus", {7'h0, pix_data_n}, {7'h0, w[20:0]});
    end
  endtask

  task automatic t_clock;
    logic [27:0] w = 28'h0F0F0F0;
    frame(w, 1'b1);
    frame(28'h7654321, 1'b1);
    chk("R6 clk shape 1111000", {21'h0, clk_seen}, {21'h0, 7'b1111000});
    chk("R6 data steady within period", {27'h0, data_steady}, 28'h1);
  endtask

  task automatic t_one_bad;
    logic [27:0] w = 28'h3C3C3C3;
    frame(28'h1111111, 1'b0);
    frame(w, 1'b1);
    chk("R7 lock kept after one bad frame", pix_data, w);
  endtask

  task automatic t_two_bad;
    frame(28'h2222222, 1'b0);
    frame(28'h3333333, 1'b0);
    chk("R8 data dropped", pix_data, 28'h0);
    chk("R8 clk dropped", {27'h0, pix_clk}, 28'h0);
    acquire("R8 reacquire");
  endtask

  task automatic t_pdn;
    @(negedge clk); pdn_n = 1'b0;
    @(posedge clk); #1;
    chk("R9 data low at once", pix_data, 28'h0);
    chk("R9 clk low at once", {27'h0, pix_clk}, 28'h0);
    for (int i = 0; i < 3; i++) begin
      frame($urandom, 1'b1);
      chk("R9 data low during power-down", pix_data, 28'h0);
      chk("R9 narrow low during power-down", {7'h0, pix_data_n}, 28'h0);
    end
    @(negedge clk); pdn_n = 1'b1;
    acquire("R9 relock");
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    t_reset();
    t_acquire();
    t_patterns();
    t_clock();
    t_one_bad();
    t_two_bad();
    t_pdn();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule